// File: doc/BRIEF.md
# Local Interrupt Priority and Acceptance Unit

This block is the per-core end of an interrupt network. Interrupt deliveries arrive carrying an 8-bit vector and a trigger mode. The unit keeps three 256-entry bit maps: vectors requested, vectors in service, and the trigger mode of each requested vector. It also holds a task priority value written by software, and from that value and the top in-service vector it derives the processor priority.

The unit offers the core the highest requested vector whose priority class (vector bits 7:4) is above the processor priority class. An acknowledge from the core moves that vector from requested to in service. An end-of-interrupt input retires the top in-service vector. When the retired vector was level-triggered, a one-cycle broadcast pulse carries that vector, so that upstream routers can re-arm their level inputs.

A delivery whose vector is already requested is merged with the existing request, and the unit reports it as coalesced. Deliveries are ignored while the unit is disabled, and so are vectors 0 to 15.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset the requested, in-service and trigger maps and the task priority are all zero. `ppr_out` is 0, `int_pending` is 0, `int_vector` is 0 and `eoi_bcast_valid` is 0.
- R2: An eligible delivery is one with `dlv_valid`=1, `sw_enable`=1 and vector >= 16. If the vector's request bit is clear, `dlv_accepted` is 1 in that cycle and the bit is set at the clock edge. If the bit is already set, `dlv_coalesced` is 1 and the maps do not change. A same-cycle acknowledge of that vector counts as clearing the bit first.
- R3: On an accepted delivery, the vector's trigger bit is set when `dlv_level`=1 (level) and cleared when `dlv_level`=0 (edge).
- R4: Deliveries of vectors 0 to 15 raise neither flag and change no state.
- R5: While `sw_enable`=0, deliveries raise neither flag and change no state.
- R6: Let isrv be the highest in-service vector, or 0 when none is in service. `ppr_out` equals the task priority when TPR[7:4] >= isrv[7:4], and {isrv[7:4], 4'h0} otherwise. It follows state combinationally.
- R7: `int_pending` is 1 exactly when a request exists whose highest vector has a class (bits 7:4) strictly greater than PPR[7:4]. `int_vector` is that vector while pending, and 0 otherwise.
- R8: `int_ack` while `int_pending` is high sets the in-service bit of `int_vector` and clears its request bit at the edge. `int_ack` without a pending interrupt is ignored.
- R9: `eoi` clears the highest in-service bit at the edge. With nothing in service, it has no effect.
- R10: In the cycle after an `eoi` that retires a vector whose trigger bit was set, `eoi_bcast_valid` is 1 and `eoi_bcast_vector` holds that vector. Otherwise `eoi_bcast_valid` is 0 and `eoi_bcast_vector` is 0.
- R11: A write with `tpr_we`=1 loads `tpr_wdata` into the task priority at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Software enable; deliveries are ignored when 0 |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| dlv_valid | input | 1 | Delivery present this cycle |
| dlv_vector | input | 8 | Delivered vector |
| dlv_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| dlv_accepted | output | 1 | Delivery accepted and queued |
| dlv_coalesced | output | 1 | Delivery merged with an existing request |
| int_pending | output | 1 | A vector is offered to the core |
| int_vector | output | 8 | Offered vector, 0 when none |
| int_ack | input | 1 | Core acknowledge of the offered vector |
| eoi | input | 1 | End of interrupt for the top in-service vector |
| eoi_bcast_valid | output | 1 | Level-triggered vector retired last cycle |
| eoi_bcast_vector | output | 8 | Vector carried by the broadcast |
| ppr_out | output | 8 | Current processor priority |

## Verification
The assertions assume that the acknowledge, end-of-interrupt and delivery inputs are driven only after reset is released, and that they are plain single-cycle strobes. The assertions place no limit on how these inputs combine. The random stimulus therefore mixes acknowledges with no pending interrupt, end-of-interrupt pulses with nothing in service, and deliveries to reserved vectors, with the unit both disabled and enabled. Delivered vectors are drawn partly from a small pool, so that coalescing and same-cycle acknowledge/delivery collisions occur often.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W   = 4;
  localparam int SUB_W   = VEC_W - CLS_W;

  typedef logic [VEC_W-1:0]   vec_t;
  typedef logic [NUM_VEC-1:0] vmap_t;
  typedef logic [CLS_W-1:0]   cls_t;

  // Priority class of a vector: its upper bits.
  function automatic cls_t cls_of(vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // Processor priority from task priority and top in-service vector.
  function automatic vec_t calc_ppr(vec_t tpr, logic isr_any, vec_t isr_top);
    vec_t isrv;
    isrv = isr_any ? isr_top : '0;
    if (cls_of(tpr) >= cls_of(isrv)) return tpr;
    return {cls_of(isrv), {SUB_W{1'b0}}};
  endfunction
endpackage

// File: rtl/irq_vec_highest.sv
module irq_vec_highest #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  map_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // Ascending scan: the last set bit seen is the highest.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (map_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_prio_pkg::*;
#(
  parameter int RSVD_VECS = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  dlv_valid_i,
  input  vec_t  dlv_vec_i,
  input  logic  dlv_level_i,
  input  logic  clr_valid_i,
  input  vec_t  clr_vec_i,
  output vmap_t irr_o,
  output vmap_t tmr_o,
  output logic  accept_o,
  output logic  coalesce_o
);
  vmap_t irr_q, tmr_q, clr_mask, set_mask, irr_live;
  logic  eligible, hit;

  always_comb begin
    clr_mask = '0;
    if (clr_valid_i) clr_mask[clr_vec_i] = 1'b1;
    irr_live   = irr_q & ~clr_mask;
    eligible   = dlv_valid_i && en_i && (int'(dlv_vec_i) >= RSVD_VECS);
    hit        = irr_live[dlv_vec_i];
    accept_o   = eligible && !hit;
    coalesce_o = eligible && hit;
    set_mask   = '0;
    if (accept_o) set_mask[dlv_vec_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_live | set_mask;
      if (accept_o) tmr_q[dlv_vec_i] <= dlv_level_i;
    end
  end

  assign irr_o = irr_q;
  assign tmr_o = tmr_q;
endmodule

// File: rtl/irq_svc_bank.sv
module irq_svc_bank
  import irq_prio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_valid_i,
  input  vec_t  set_vec_i,
  input  logic  eoi_i,
  input  logic  isr_any_i,
  input  vec_t  isr_top_i,
  input  vmap_t tmr_i,
  output vmap_t isr_o,
  output logic  eoi_fire_o,
  output logic  bcast_valid_o,
  output vec_t  bcast_vec_o
);
  vmap_t isr_q, set_mask, eoi_mask;
  logic  bcast_q;
  vec_t  bvec_q;

  always_comb begin
    eoi_fire_o = eoi_i && isr_any_i;
    set_mask = '0;
    eoi_mask = '0;
    if (set_valid_i) set_mask[set_vec_i] = 1'b1;
    if (eoi_fire_o)  eoi_mask[isr_top_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q   <= '0;
      bcast_q <= 1'b0;
      bvec_q  <= '0;
    end else begin
      isr_q   <= (isr_q & ~eoi_mask) | set_mask;
      bcast_q <= eoi_fire_o && tmr_i[isr_top_i];
      bvec_q  <= (eoi_fire_o && tmr_i[isr_top_i]) ? isr_top_i : '0;
    end
  end

  assign isr_o         = isr_q;
  assign bcast_valid_o = bcast_q;
  assign bcast_vec_o   = bvec_q;
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int RSVD_VECS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_enable,
  input  logic       tpr_we,
  input  logic [7:0] tpr_wdata,
  input  logic       dlv_valid,
  input  logic [7:0] dlv_vector,
  input  logic       dlv_level,
  output logic       dlv_accepted,
  output logic       dlv_coalesced,
  output logic       int_pending,
  output logic [7:0] int_vector,
  input  logic       int_ack,
  input  logic       eoi,
  output logic       eoi_bcast_valid,
  output logic [7:0] eoi_bcast_vector,
  output logic [7:0] ppr_out
);
  vec_t  tpr_q, irr_top, isr_top, ppr;
  vmap_t irr, isr, tmr;
  logic  irr_any, isr_any, ack_fire, eoi_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tpr_q <= '0;
    else if (tpr_we) tpr_q <= tpr_wdata;
  end

  irq_vec_highest #(.W(NUM_VEC)) u_irr_enc (.map_i(irr), .any_o(irr_any), .idx_o(irr_top));
  irq_vec_highest #(.W(NUM_VEC)) u_isr_enc (.map_i(isr), .any_o(isr_any), .idx_o(isr_top));

  always_comb begin
    ppr         = calc_ppr(tpr_q, isr_any, isr_top);
    int_pending = irr_any && (cls_of(irr_top) > cls_of(ppr));
    int_vector  = int_pending ? irr_top : '0;
    ack_fire    = int_ack && int_pending;
  end

  irq_req_bank #(.RSVD_VECS(RSVD_VECS)) u_req (
    .clk(clk), .rst_n(rst_n), .en_i(sw_enable),
    .dlv_valid_i(dlv_valid), .dlv_vec_i(dlv_vector), .dlv_level_i(dlv_level),
    .clr_valid_i(ack_fire), .clr_vec_i(irr_top),
    .irr_o(irr), .tmr_o(tmr),
    .accept_o(dlv_accepted), .coalesce_o(dlv_coalesced)
  );

  irq_svc_bank u_svc (
    .clk(clk), .rst_n(rst_n),
    .set_valid_i(ack_fire), .set_vec_i(irr_top),
    .eoi_i(eoi), .isr_any_i(isr_any), .isr_top_i(isr_top), .tmr_i(tmr),
    .isr_o(isr), .eoi_fire_o(eoi_fire),
    .bcast_valid_o(eoi_bcast_valid), .bcast_vec_o(eoi_bcast_vector)
  );

  assign ppr_out = ppr;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int RSVD_VECS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_enable,
  input logic       dlv_valid,
  input logic [7:0] dlv_vector,
  input logic       dlv_accepted,
  input logic       dlv_coalesced,
  input logic       int_pending,
  input logic [7:0] int_vector,
  input logic [7:0] ppr_out,
  input logic [7:0] tpr_q,
  input logic       eoi,
  input logic       eoi_fire,
  input logic       ack_fire,
  input logic       eoi_bcast_valid
);
  assert_pend_above_ppr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_pending |-> (cls_of(int_vector) > cls_of(ppr_out)));
  assert_idle_vector_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_pending |-> (int_vector == 8'h00));
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(dlv_accepted && dlv_coalesced));
  assert_disabled_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enable |-> (!dlv_accepted && !dlv_coalesced));
  assert_reserved_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dlv_vector) < RSVD_VECS) |-> (!dlv_accepted && !dlv_coalesced));
  assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid |-> (!dlv_accepted && !dlv_coalesced));
  assert_ppr_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_out >= tpr_q);
  assert_ack_lifts_ppr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (cls_of(ppr_out) >= $past(cls_of(int_vector))));
  assert_bcast_follows_eoi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> ($past(eoi) && $past(eoi_fire)));
endmodule

bind irq_prio_unit irq_prio_chk #(.RSVD_VECS(RSVD_VECS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
  .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
  .dlv_accepted(dlv_accepted), .dlv_coalesced(dlv_coalesced),
  .int_pending(int_pending), .int_vector(int_vector), .ppr_out(ppr_out),
  .tpr_q(tpr_q), .eoi(eoi), .eoi_fire(eoi_fire), .ack_fire(ack_fire),
  .eoi_bcast_valid(eoi_bcast_valid)
);

// File: tb/test_irq_prio_unit.sv
module test_irq_prio_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_enable = 1'b0, tpr_we = 1'b0, dlv_valid = 1'b0, dlv_level = 1'b0;
  logic int_ack = 1'b0, eoi = 1'b0;
  logic [7:0] tpr_wdata = '0, dlv_vector = '0;
  logic dlv_accepted, dlv_coalesced, int_pending, eoi_bcast_valid;
  logic [7:0] int_vector, eoi_bcast_vector, ppr_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  logic [7:0]   m_tpr = '0;

  always #10 clk = ~clk;

  irq_prio_unit i_irq_prio_unit (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Model: highest set vector by a descending search.
  function automatic void m_top(input logic [255:0] m, output logic has, output logic [7:0] v);
    has = 0; v = '0;
    for (int i = 255; i >= 0; i--) if (!has && m[i]) begin has = 1; v = 8'(i); end
  endfunction

  function automatic logic [7:0] m_ppr(input logic [7:0] t, input logic has, input logic [7:0] top);
    if (has && top[7:4] > t[7:4]) return {top[7:4], 4'h0};
    return t;
  endfunction

  task automatic step(input logic sw, input logic twe, input logic [7:0] td,
                      input logic dv, input logic [7:0] dvec, input logic dl,
                      input logic ak, input logic eo);
    logic [255:0] live;
    logic irr_has, isr_has, pend, elig, acc_e, coal_e, bc_e;
    logic [7:0] pv, ev, ppr_e;
    string atag;
    sw_enable = sw; tpr_we = twe; tpr_wdata = td; dlv_valid = dv;
    dlv_vector = dvec; dlv_level = dl; int_ack = ak; eoi = eo;
    #2;
    m_top(m_irr, irr_has, pv);
    m_top(m_isr, isr_has, ev);
    ppr_e = m_ppr(m_tpr, isr_has, ev);
    pend  = irr_has && (pv[7:4] > ppr_e[7:4]);
    live  = m_irr;
    if (ak && pend) live[pv] = 1'b0;
    elig   = dv && sw && (dvec >= 8'd16);
    acc_e  = elig && !live[dvec];
    coal_e = elig && live[dvec];
    atag = !sw ? "R5" : (dvec < 8'd16 ? "R4" : "R2");
    chk("R6", {8'h0, ppr_out}, {8'h0, ppr_e});
    chk("R7", {7'h0, int_pending, int_vector}, {7'h0, pend, pend ? pv : 8'h0});
    chk(atag, {14'h0, dlv_accepted, dlv_coalesced}, {14'h0, acc_e, coal_e});
    bc_e = eo && isr_has && m_tmr[ev];
    @(posedge clk);
    m_irr = live;
    if (acc_e) begin m_irr[dvec] = 1'b1; m_tmr[dvec] = dl; end
    if (eo && isr_has) m_isr[ev] = 1'b0;
    if (ak && pend) m_isr[pv] = 1'b1;
    if (twe) m_tpr = td;
    @(negedge clk);
    chk("R10", {7'h0, eoi_bcast_valid, eoi_bcast_vector}, {7'h0, bc_e, bc_e ? ev : 8'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5021));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {6'h0, int_pending, eoi_bcast_valid, ppr_out}, 16'h0);
    chk("R1", {8'h0, int_vector}, 16'h0);
    // R11: task priority write
    step(1, 1, 8'h20, 0, 8'h00, 0, 0, 0);
    chk("R11", {8'h0, ppr_out}, 16'h0020);
    step(1, 0, 0, 1, 8'h25, 1, 0, 0);   // R2 accept, class equal to TPR: not pending
    chk("R7", {7'h0, int_pending, int_vector}, 16'h0);
    step(1, 0, 0, 1, 8'h45, 0, 0, 0);   // R2 accept edge
    step(1, 0, 0, 1, 8'h45, 1, 0, 0);   // R2 coalesced
    step(1, 0, 0, 1, 8'h05, 1, 0, 0);   // R4 reserved
    step(0, 0, 0, 1, 8'h80, 1, 0, 0);   // R5 disabled
    chk("R5", {7'h0, int_pending, int_vector}, 16'h0145);
    step(1, 0, 0, 0, 8'h00, 0, 1, 0);   // R8 acknowledge 0x45
    chk("R8", {7'h0, int_pending, ppr_out}, 16'h0040);
    step(1, 0, 0, 1, 8'h90, 1, 0, 0);
    step(1, 0, 0, 0, 8'h00, 0, 1, 0);   // ack 0x90
    chk("R8", {8'h0, ppr_out}, 16'h0090);
    step(1, 0, 0, 0, 8'h00, 0, 0, 1);   // retire level 0x90
    chk("R3", {7'h0, eoi_bcast_valid, eoi_bcast_vector}, 16'h0190);
    chk("R9", {8'h0, ppr_out}, 16'h0040);
    step(1, 0, 0, 0, 8'h00, 0, 0, 1);   // retire edge 0x45
    chk("R3", {7'h0, eoi_bcast_valid}, 16'h0);
    chk("R9", {8'h0, ppr_out}, 16'h0020);
    step(1, 0, 0, 0, 8'h00, 0, 0, 1);   // R9 eoi with nothing in service
    chk("R9", {8'h0, ppr_out}, 16'h0020);
    step(1, 0, 0, 0, 8'h00, 0, 1, 0);   // R8 ack without pending ignored
    chk("R8", {8'h0, ppr_out}, 16'h0020);
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] v;
      v = ($urandom_range(0, 1) == 0) ? 8'(8'h10 + 8'h10 * $urandom_range(0, 7) + $urandom_range(0, 2))
                                      : 8'($urandom_range(0, 255));
      step($urandom_range(0, 9) != 0, $urandom_range(0, 29) == 0, 8'($urandom_range(0, 255)),
           $urandom_range(0, 2) != 0, v, 1'($urandom_range(0, 1)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0);
    end
    step(1, 0, 0, 0, 8'h00, 0, 0, 0);
    finish_run();
  end
endmodule